// File: doc/BRIEF.md
# DMA Channel Interrupt Collector

This block gathers single-cycle event pulses from up to sixteen DMA channel engines and turns them into sticky, software-visible interrupt state. Four event classes are kept per channel: completion of a whole transfer chain, completion of one node (period) of a chain, and two independent error classes. Each class has a sticky raw register, an enable register, and a read-only view of the raw bits that are enabled.

A combined register reports, per channel, whether any enabled class is pending, so an interrupt handler can find the channels that need service by scanning it from bit 0 upward. One registered interrupt line goes to the processor. Software reads and writes the state through a simple register port: address, write strobe and write data, with read data returned combinationally for the address presented. Stopping a channel is done by writing a one-hot value to each of the four raw registers.

Top module: `dma_irq_collector`

## Requirements
- R1: After reset every raw and enable register is zero, `irqOut` is low, and every mapped offset reads zero.
- R2: A pulse on a class input for channel i sets bit i of that class's raw register on the next clock edge, and the bit stays set until software clears it; a raw bit never becomes set without an event.
- R3: Writing to a raw register clears every bit written as 1 and leaves every bit written as 0 unchanged. Raw registers are at 0x600 (chain done), 0x608 (node done), 0x610 (error A) and 0x618 (error B), and read back their current value.
- R4: When an event and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R5: Enable registers are at 0x018 (chain done), 0x01C (node done), 0x020 (error A) and 0x024 (error B); a write replaces the whole value and a read returns it. A 1 in bit i enables channel i of that class.
- R6: The masked views at 0x004 (chain done), 0x008 (node done), 0x00C (error A) and 0x010 (error B) read as the raw value ANDed with the enable value of the same class.
- R7: The combined register at 0x000 has bit i set exactly when any of the four masked views has bit i set; error classes count toward it.
- R8: `irqOut` equals the OR of all combined bits as they stood one clock earlier; it rises one cycle after the first enabled pending bit appears and falls one cycle after the last one goes away.
- R9: Writes to the combined register or the masked views change no state.
- R10: Any offset not listed in R3, R5, R6 and R7 reads zero, and writes to it change no state.
- R11: Writing the one-hot value for channel i to all four raw registers clears channel i in every class and leaves every other channel's bits as they were.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| evtChain | input | NCH | Chain-complete event pulse, one bit per channel |
| evtNode | input | NCH | Node-complete event pulse, one bit per channel |
| evtErrA | input | NCH | Error class A event pulse, one bit per channel |
| evtErrB | input | NCH | Error class B event pulse, one bit per channel |
| regAddr | input | 12 | Register byte offset |
| regWrEn | input | 1 | Write strobe for the current offset |
| regWrData | input | NCH | Write data, one bit per channel |
| regRdData | output | NCH | Read data for the current offset, combinational |
| irqOut | output | 1 | Registered interrupt request to the processor |

## Verification
The collector is driven with events spread over different classes and channels at once, so a mix-up between classes or channel bits shows up in the raw, masked and combined reads. Clearing writes with all-zero data, with one-hot data and with data that lands in the same cycle as a new event tell apart a correct write-one-to-clear from a plain overwrite or a clear that wins over the event. Partial enable patterns, including disabling only the node class while errors stay enabled, separate correct masking and error counting in the combined view from a combined view built on raw bits. Writes to read-only and unmapped offsets, followed by readback of every register, show that no state was touched.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;

  localparam int NCLASS = 4;   // 0 chain done, 1 node done, 2 error A, 3 error B
  localparam int ADDR_W = 12;

  localparam logic [ADDR_W-1:0] OFF_PEND = 12'h000;

  function automatic logic [ADDR_W-1:0] maskedOff(input int cls);
    return ADDR_W'(12'h004 + 4 * cls);
  endfunction

  function automatic logic [ADDR_W-1:0] enableOff(input int cls);
    return ADDR_W'(12'h018 + 4 * cls);
  endfunction

  function automatic logic [ADDR_W-1:0] rawOff(input int cls);
    return ADDR_W'(12'h600 + 8 * cls);
  endfunction

  typedef enum logic [2:0] {
    RD_NONE,
    RD_PEND,
    RD_MASKED,
    RD_ENABLE,
    RD_RAW
  } rdKind_e;

  typedef struct packed {
    logic [NCLASS-1:0] rawClr;
    logic [NCLASS-1:0] enableWr;
    rdKind_e           rdKind;
    logic [1:0]        rdClass;
  } regStrobe_t;

endpackage

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
  import dma_irq_pkg::*;
(
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output regStrobe_t        strb
);

  always_comb begin
    strb = '{rawClr: '0, enableWr: '0, rdKind: RD_NONE, rdClass: 2'd0};
    if (regAddr == OFF_PEND) begin
      strb.rdKind = RD_PEND;
    end
    for (int cls = 0; cls < NCLASS; cls++) begin
      if (regAddr == maskedOff(cls)) begin
        strb.rdKind  = RD_MASKED;
        strb.rdClass = 2'(cls);
      end
      if (regAddr == enableOff(cls)) begin
        strb.rdKind        = RD_ENABLE;
        strb.rdClass       = 2'(cls);
        strb.enableWr[cls] = regWrEn;
      end
      if (regAddr == rawOff(cls)) begin
        strb.rdKind      = RD_RAW;
        strb.rdClass     = 2'(cls);
        strb.rawClr[cls] = regWrEn;
      end
    end
  end

endmodule

// File: rtl/dma_irq_datapath.sv
module dma_irq_datapath
  import dma_irq_pkg::*;
#(
  parameter int NCH = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NCLASS-1:0][NCH-1:0] evtAll,
  input  regStrobe_t                 strb,
  input  logic [NCH-1:0]             wrData,
  output logic [NCLASS-1:0][NCH-1:0] rawAll,
  output logic [NCLASS-1:0][NCH-1:0] enableAll,
  output logic [NCH-1:0]             rdData,
  output logic                       irqOut
);

  logic [NCLASS-1:0][NCH-1:0] maskedAll;
  logic [NCH-1:0]             pendVec;

  for (genvar cls = 0; cls < NCLASS; cls++) begin : gClass
    logic [NCH-1:0] clrBits;
    assign clrBits        = strb.rawClr[cls] ? wrData : '0;
    assign maskedAll[cls] = rawAll[cls] & enableAll[cls];

    // event is OR-ed in after the clear, so a coincident event survives
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        rawAll[cls] <= '0;
      end else begin
        rawAll[cls] <= (rawAll[cls] & ~clrBits) | evtAll[cls];
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        enableAll[cls] <= '0;
      end else if (strb.enableWr[cls]) begin
        enableAll[cls] <= wrData;
      end
    end
  end

  always_comb begin
    pendVec = '0;
    for (int cls = 0; cls < NCLASS; cls++) begin
      pendVec = pendVec | maskedAll[cls];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqOut <= 1'b0;
    end else begin
      irqOut <= |pendVec;
    end
  end

  always_comb begin
    unique case (strb.rdKind)
      RD_PEND:   rdData = pendVec;
      RD_MASKED: rdData = maskedAll[strb.rdClass];
      RD_ENABLE: rdData = enableAll[strb.rdClass];
      RD_RAW:    rdData = rawAll[strb.rdClass];
      default:   rdData = '0;
    endcase
  end

endmodule

// File: rtl/dma_irq_collector.sv
module dma_irq_collector
  import dma_irq_pkg::*;
#(
  parameter int NCH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NCH-1:0]    evtChain,
  input  logic [NCH-1:0]    evtNode,
  input  logic [NCH-1:0]    evtErrA,
  input  logic [NCH-1:0]    evtErrB,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [NCH-1:0]    regWrData,
  output logic [NCH-1:0]    regRdData,
  output logic              irqOut
);

  regStrobe_t                 strb;
  logic [NCLASS-1:0][NCH-1:0] evtAll;
  logic [NCLASS-1:0][NCH-1:0] rawAll;
  logic [NCLASS-1:0][NCH-1:0] enableAll;

  assign evtAll = {evtErrB, evtErrA, evtNode, evtChain};

  dma_irq_ctrl u_ctrl (
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .strb    (strb)
  );

  dma_irq_datapath #(.NCH(NCH)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .evtAll    (evtAll),
    .strb      (strb),
    .wrData    (regWrData),
    .rawAll    (rawAll),
    .enableAll (enableAll),
    .rdData    (regRdData),
    .irqOut    (irqOut)
  );

endmodule

// File: rtl/dma_irq_checker.sv
module dma_irq_checker
  import dma_irq_pkg::*;
#(
  parameter int NCH = 16
) (
  input logic                       clk,
  input logic                       rstN,
  input logic [NCLASS-1:0][NCH-1:0] evtAll,
  input logic [NCLASS-1:0][NCH-1:0] rawAll,
  input logic [NCLASS-1:0][NCH-1:0] enableAll,
  input logic [ADDR_W-1:0]          regAddr,
  input logic                       regWrEn,
  input logic [NCH-1:0]             regWrData,
  input logic                       irqOut
);

  logic enableHit;
  always_comb begin
    enableHit = 1'b0;
    for (int cls = 0; cls < NCLASS; cls++) begin
      if (regAddr == enableOff(cls)) enableHit = 1'b1;
    end
  end

  assert_evt_latch_R2: assert property (@(posedge clk) disable iff (!rstN)
    (evtAll != '0) |=> ((rawAll & $past(evtAll)) == $past(evtAll)));

  assert_raw_rise_R2: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((rawAll & ~$past(rawAll) & ~$past(evtAll)) == '0));

  assert_irq_delay_R8: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irqOut == $past(|(rawAll & enableAll))));

  assert_enable_offset_only_R10: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && !enableHit) |=> $stable(enableAll));

  for (genvar cls = 0; cls < NCLASS; cls++) begin : gChk
    assert_w1c_clears_R3: assert property (@(posedge clk) disable iff (!rstN)
      (regWrEn && regAddr == rawOff(cls)) |=>
        ((rawAll[cls] & $past(regWrData) & ~$past(evtAll[cls])) == '0));

    assert_event_beats_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
      (regWrEn && regAddr == rawOff(cls) && evtAll[cls] != '0) |=>
        ((rawAll[cls] & $past(evtAll[cls])) == $past(evtAll[cls])));
  end

endmodule

bind dma_irq_collector dma_irq_checker #(.NCH(NCH)) u_checker (
  .clk       (clk),
  .rstN      (rstN),
  .evtAll    (evtAll),
  .rawAll    (rawAll),
  .enableAll (enableAll),
  .regAddr   (regAddr),
  .regWrEn   (regWrEn),
  .regWrData (regWrData),
  .irqOut    (irqOut)
);

// File: tb/test_dma_irq_collector.sv
`timescale 1ns/100ps
module test_dma_irq_collector;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] evtChain = '0, evtNode = '0, evtErrA = '0, evtErrB = '0;
  logic [11:0] regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        irqOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference state
  logic [15:0] mRaw [4];
  logic [15:0] mEn  [4];
  logic        mIrq;

  always #2.5 clk = ~clk;

  dma_irq_collector #(.NCH(16)) i_dma_irq_collector (
    .clk(clk), .rstN(rstN),
    .evtChain(evtChain), .evtNode(evtNode), .evtErrA(evtErrA), .evtErrB(evtErrB),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .irqOut(irqOut)
  );

  function automatic logic [15:0] mPend();
    logic [15:0] p = '0;
    for (int c = 0; c < 4; c++) p |= mRaw[c] & mEn[c];
    return p;
  endfunction

  function automatic logic [15:0] mRead(input logic [11:0] a);
    for (int c = 0; c < 4; c++) begin
      if (a == 12'h004 + 12'(4 * c)) return mRaw[c] & mEn[c];
      if (a == 12'h018 + 12'(4 * c)) return mEn[c];
      if (a == 12'h600 + 12'(8 * c)) return mRaw[c];
    end
    if (a == 12'h000) return mPend();
    return '0;
  endfunction

  task automatic check(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s at offset 0x%03h: actual 0x%04h expected 0x%04h", tag, what, regAddr, act, exp);
    end
  endtask

  // one clock: drive, compare against model, then advance model at the edge
  task automatic cyc(input logic [15:0] e0, input logic [15:0] e1, input logic [15:0] e2,
                     input logic [15:0] e3, input logic we, input logic [11:0] a,
                     input logic [15:0] d, input string tag);
    logic [15:0] ev [4];
    @(negedge clk);
    evtChain = e0; evtNode = e1; evtErrA = e2; evtErrB = e3;
    regWrEn = we; regAddr = a; regWrData = d;
    #1;
    check(tag, "read", regRdData, mRead(a));
    check(tag, "irq", {15'd0, irqOut}, {15'd0, mIrq});
    ev[0] = e0; ev[1] = e1; ev[2] = e2; ev[3] = e3;
    @(posedge clk);
    mIrq = |mPend();
    for (int c = 0; c < 4; c++) begin
      if (we && a == 12'h600 + 12'(8 * c)) mRaw[c] = mRaw[c] & ~d;
      mRaw[c] = mRaw[c] | ev[c];
      if (we && a == 12'h018 + 12'(4 * c)) mEn[c] = d;
    end
  endtask

  task automatic rd(input logic [11:0] a, input string tag);
    cyc('0, '0, '0, '0, 1'b0, a, '0, tag);
  endtask

  task automatic wr(input logic [11:0] a, input logic [15:0] d, input string tag);
    cyc('0, '0, '0, '0, 1'b1, a, d, tag);
  endtask

  task automatic readAll(input string tag);
    logic [11:0] offs [13] = '{12'h000, 12'h004, 12'h008, 12'h00C, 12'h010,
                              12'h018, 12'h01C, 12'h020, 12'h024,
                              12'h600, 12'h608, 12'h610, 12'h618};
    for (int k = 0; k < 13; k++) rd(offs[k], tag);
  endtask

  initial begin
    #100000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 4; c++) begin mRaw[c] = '0; mEn[c] = '0; end
    mIrq = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1: reset state
    readAll("R1");

    // R5: enable every channel of every class, read back
    wr(12'h018, 16'hFFFF, "R5"); wr(12'h01C, 16'hFFFF, "R5");
    wr(12'h020, 16'hFFFF, "R5"); wr(12'h024, 16'hFFFF, "R5");
    rd(12'h020, "R5");

    // R2/R6/R7/R8: events spread over classes and channels
    cyc(16'h0001, 16'h0008, 16'h8000, 16'h0080, 1'b0, 12'h000, '0, "R2");
    rd(12'h000, "R7");
    rd(12'h000, "R8");
    readAll("R6");

    // R3: zero write keeps bits, one-hot clears
    wr(12'h600, 16'h0000, "R3"); rd(12'h600, "R3");
    wr(12'h600, 16'h0001, "R3"); rd(12'h600, "R3"); rd(12'h000, "R3");

    // R4: event and clear on the same bit in the same cycle
    cyc(16'h0020, '0, '0, '0, 1'b1, 12'h600, 16'h0020, "R4");
    rd(12'h600, "R4"); rd(12'h004, "R4");

    // R6/R7: disable node class only; errors still count
    wr(12'h01C, 16'h0000, "R6"); rd(12'h008, "R6"); rd(12'h608, "R6");
    rd(12'h000, "R7");
    wr(12'h020, 16'h00FF, "R6"); rd(12'h00C, "R6"); rd(12'h000, "R7");

    // R9: writes to combined and masked views do nothing
    wr(12'h000, 16'hFFFF, "R9"); wr(12'h004, 16'hFFFF, "R9");
    wr(12'h010, 16'hFFFF, "R9");
    readAll("R9");

    // R10: unmapped offsets read zero, writes ignored
    wr(12'h014, 16'hFFFF, "R10"); rd(12'h014, "R10");
    wr(12'h604, 16'hFFFF, "R10"); rd(12'h604, "R10");
    wr(12'h100, 16'h0000, "R10"); rd(12'h61C, "R10");
    readAll("R10");

    // R11: abort channel 7 with one-hot writes to all raw registers
    cyc(16'h00C0, 16'h00C0, 16'h00C0, 16'h00C0, 1'b0, 12'h000, '0, "R11");
    wr(12'h600, 16'h0080, "R11"); wr(12'h608, 16'h0080, "R11");
    wr(12'h610, 16'h0080, "R11"); wr(12'h618, 16'h0080, "R11");
    readAll("R11");

    // R8: clear everything, interrupt falls one cycle later
    wr(12'h600, 16'hFFFF, "R8"); wr(12'h608, 16'hFFFF, "R8");
    wr(12'h610, 16'hFFFF, "R8"); wr(12'h618, 16'hFFFF, "R8");
    rd(12'h000, "R8"); rd(12'h000, "R8");
    // R8: masked-only pending does not raise the line
    wr(12'h018, 16'h0000, "R8");
    cyc(16'h0004, '0, '0, '0, 1'b0, 12'h600, '0, "R8");
    rd(12'h000, "R8"); rd(12'h600, "R8");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule